// File: doc/BRIEF.md
# Fence Ordering Set Widener

A combinational stage that sits between fence decode and the memory ordering logic. It receives the predecessor and successor ordering sets of a decoded fence, plus the acquire, release and I/O-region flags of an atomic operation. It returns the ordering sets and the ordering domain that the memory system must actually honour.

When widening is active, a device-input bit also asks for ordering of memory reads, and a device-output bit also asks for ordering of memory writes. An atomic operation to an I/O region that carries acquire or release is then ordered against both the I/O and the memory domain. Widening is turned on in two ways. The first is a guest running in virtualized mode whose hypervisor-level configuration bit is set. The second is the machine-level bit being set while the hart runs below machine mode. In every other case the inputs pass through unchanged.

Top module: `fence_widen`

## Requirements
- R1: With widening active, predecessor device input (pred bit 3) also sets predecessor memory read (pred bit 1).
- R2: With widening active, predecessor device output (pred bit 2) also sets predecessor memory write (pred bit 0).
- R3: With widening active, successor bits 3 and 2 set successor bits 1 and 0 in the same way.
- R4: In virtualized mode (virt_i=1), widening is active when hcfg_fiom_i=1. With both configuration bits clear, it is inactive.
- R5: With mcfg_fiom_i=1, widening is active at user (priv 2'b00) and supervisor (priv 2'b01) level, whether or not the hart is virtualized.
- R6: Widening is inactive at machine level (priv 2'b11), and also when only hcfg_fiom_i is set outside virtualized mode. While inactive, both sets pass through unchanged.
- R7: Widening never clears a bit, and the device bits (3 and 2) of each output set always equal those of the input set.
- R8: With widening active, an atomic operation with io_i=1 and aq_i or rl_i set yields domain 2'b11 (bit 1 = I/O, bit 0 = memory).
- R9: An atomic operation with neither aq_i nor rl_i set yields its plain region domain: 2'b10 for I/O, 2'b01 for memory.
- R10: An atomic operation to a memory region (io_i=0) always yields domain 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| virt_i | input | 1 | Hart runs in virtualized mode |
| priv_i | input | 2 | Privilege level: 00 user, 01 supervisor, 11 machine |
| hcfg_fiom_i | input | 1 | Hypervisor-level I/O-fence-orders-memory bit |
| mcfg_fiom_i | input | 1 | Machine-level I/O-fence-orders-memory bit |
| pred_i | input | 4 | Predecessor set {dev_in, dev_out, mem_rd, mem_wr} |
| succ_i | input | 4 | Successor set, same layout |
| amo_aq_i | input | 1 | Atomic acquire flag |
| amo_rl_i | input | 1 | Atomic release flag |
| amo_io_i | input | 1 | Atomic targets an I/O-ordered region |
| pred_o | output | 4 | Effective predecessor set |
| succ_o | output | 4 | Effective successor set |
| amo_dom_o | output | 2 | Atomic ordering domain {io, mem} |

## Verification
The assertions take two facts about the inputs for granted. Virtualized mode only occurs below machine level, and priv_i never carries the reserved code 2'b10. The assertions guard these two facts directly. The bench drives only the codes 00, 01 and 11, and it sets virt_i only together with user or supervisor level. All inputs start from defined zeros, so no check sees an unknown value at time zero.

// File: rtl/fence_widen_pkg.sv
package fence_widen_pkg;
  localparam int unsigned ORD_W   = 4;
  localparam int unsigned N_SETS  = 2;
  localparam int unsigned DOM_W   = 2;
  localparam int unsigned B_DIN   = 3;
  localparam int unsigned B_DOUT  = 2;
  localparam int unsigned B_MRD   = 1;
  localparam int unsigned B_MWR   = 0;
  localparam int unsigned D_IO    = 1;
  localparam int unsigned D_MEM   = 0;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef logic [ORD_W-1:0] ord_set_t;
  typedef logic [DOM_W-1:0] ord_dom_t;
endpackage

// File: rtl/widen_enable.sv
module widen_enable
  import fence_widen_pkg::*;
(
  input  logic       virt_i,
  input  logic [1:0] priv_i,
  input  logic       hcfg_fiom_i,
  input  logic       mcfg_fiom_i,
  output logic       active_o
);
  logic below_m;
  logic guest_req;
  logic host_req;

  assign below_m   = (priv_i != PRIV_M);
  assign guest_req = virt_i & hcfg_fiom_i;
  assign host_req  = mcfg_fiom_i & below_m;
  assign active_o  = guest_req | host_req;

  always_comb begin
    p_priv_legal_r6: assert (priv_i != 2'b10)
      else $error("reserved privilege code");
    p_virt_below_m_r4: assert (!(virt_i && priv_i == 2'b11))
      else $error("virtualized at machine level");
    p_m_inactive_r6: assert (!(priv_i == 2'b11) || !active_o)
      else $error("widening active at machine level");
    p_guest_on_r4: assert (!(virt_i && hcfg_fiom_i) || active_o)
      else $error("guest request not honoured");
    p_host_on_r5: assert (!(mcfg_fiom_i && priv_i != 2'b11) || active_o)
      else $error("machine request not honoured");
  end
endmodule

// File: rtl/set_widen.sv
module set_widen
  import fence_widen_pkg::*;
(
  input  logic           active_i,
  input  logic [ORD_W-1:0] set_i,
  output logic [ORD_W-1:0] set_o
);
  logic add_rd;
  logic add_wr;

  assign add_rd = active_i & set_i[B_DIN];
  assign add_wr = active_i & set_i[B_DOUT];

  always_comb begin
    set_o        = set_i;
    set_o[B_MRD] = set_i[B_MRD] | add_rd;
    set_o[B_MWR] = set_i[B_MWR] | add_wr;
  end

  always_comb begin
    p_no_clear_r7: assert ((set_o & set_i) == set_i)
      else $error("widening cleared a bit");
    p_dev_kept_r7: assert (set_o[B_DIN] == set_i[B_DIN] && set_o[B_DOUT] == set_i[B_DOUT])
      else $error("device bit altered");
    p_pass_r6: assert (active_i || set_o == set_i)
      else $error("inactive widener altered set");
    p_in_rd_r1: assert (!(active_i && set_i[B_DIN]) || set_o[B_MRD])
      else $error("input did not imply read");
    p_out_wr_r2: assert (!(active_i && set_i[B_DOUT]) || set_o[B_MWR])
      else $error("output did not imply write");
  end
endmodule

// File: rtl/amo_domain.sv
module amo_domain
  import fence_widen_pkg::*;
(
  input  logic             active_i,
  input  logic             aq_i,
  input  logic             rl_i,
  input  logic             io_i,
  output logic [DOM_W-1:0] dom_o
);
  logic [DOM_W-1:0] base_dom;
  logic             ordered;
  logic             widen;

  always_comb begin
    base_dom        = '0;
    base_dom[D_IO]  = io_i;
    base_dom[D_MEM] = ~io_i;
  end

  assign ordered = aq_i | rl_i;
  assign widen   = active_i & io_i & ordered;

  always_comb begin
    dom_o        = base_dom;
    dom_o[D_MEM] = base_dom[D_MEM] | widen;
  end

  always_comb begin
    p_plain_amo_r9: assert (aq_i || rl_i || dom_o == {io_i, ~io_i})
      else $error("unordered atomic widened");
    p_mem_region_r10: assert (io_i || dom_o == 2'b01)
      else $error("memory region domain wrong");
    p_io_both_r8: assert (!(active_i && io_i && (aq_i || rl_i)) || dom_o == 2'b11)
      else $error("ordered I/O atomic not widened");
    p_onehot_inactive_r9: assert (active_i || $onehot(dom_o))
      else $error("inactive domain not one-hot");
  end
endmodule

// File: rtl/fence_widen.sv
module fence_widen
  import fence_widen_pkg::*;
(
  input  logic             virt_i,
  input  logic [1:0]       priv_i,
  input  logic             hcfg_fiom_i,
  input  logic             mcfg_fiom_i,
  input  logic [ORD_W-1:0] pred_i,
  input  logic [ORD_W-1:0] succ_i,
  input  logic             amo_aq_i,
  input  logic             amo_rl_i,
  input  logic             amo_io_i,
  output logic [ORD_W-1:0] pred_o,
  output logic [ORD_W-1:0] succ_o,
  output logic [DOM_W-1:0] amo_dom_o
);
  localparam int unsigned IDX_PRED = 0;
  localparam int unsigned IDX_SUCC = 1;

  logic             active;
  logic [ORD_W-1:0] sets_in  [N_SETS];
  logic [ORD_W-1:0] sets_out [N_SETS];

  widen_enable u_enable (
    .virt_i      (virt_i),
    .priv_i      (priv_i),
    .hcfg_fiom_i (hcfg_fiom_i),
    .mcfg_fiom_i (mcfg_fiom_i),
    .active_o    (active)
  );

  assign sets_in[IDX_PRED] = pred_i;
  assign sets_in[IDX_SUCC] = succ_i;

  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    set_widen u_set (
      .active_i (active),
      .set_i    (sets_in[g]),
      .set_o    (sets_out[g])
    );
  end

  assign pred_o = sets_out[IDX_PRED];
  assign succ_o = sets_out[IDX_SUCC];

  amo_domain u_amo (
    .active_i (active),
    .aq_i     (amo_aq_i),
    .rl_i     (amo_rl_i),
    .io_i     (amo_io_i),
    .dom_o    (amo_dom_o)
  );

  always_comb begin
    p_succ_in_rd_r3: assert (!(active && succ_i[B_DIN]) || succ_o[B_MRD])
      else $error("successor input did not imply read");
    p_succ_out_wr_r3: assert (!(active && succ_i[B_DOUT]) || succ_o[B_MWR])
      else $error("successor output did not imply write");
    p_cfg_off_r4: assert (hcfg_fiom_i || mcfg_fiom_i || (pred_o == pred_i && succ_o == succ_i))
      else $error("sets altered with both bits clear");
  end
endmodule

// File: tb/fence_widen_tb.sv
module fence_widen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [3:0] req;
    logic       virt;
    logic [1:0] priv;
    logic       hcfg;
    logic       mcfg;
    logic [3:0] pred;
    logic [3:0] succ;
    logic       aq;
    logic       rl;
    logic       io;
    logic [3:0] e_pred;
    logic [3:0] e_succ;
    logic [1:0] e_dom;
  } vec_t;

  localparam int N_VEC = 14;
  localparam vec_t VECS [N_VEC] = '{
    '{4'd1,  1'b1, 2'b01, 1'b1, 1'b0, 4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b0000, 2'b01},
    '{4'd2,  1'b1, 2'b00, 1'b1, 1'b0, 4'b0100, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0101, 4'b0000, 2'b01},
    '{4'd3,  1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b1100, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1111, 2'b01},
    '{4'd4,  1'b1, 2'b01, 1'b0, 1'b0, 4'b1100, 4'b1100, 1'b1, 1'b0, 1'b1, 4'b1100, 4'b1100, 2'b10},
    '{4'd5,  1'b0, 2'b01, 1'b0, 1'b1, 4'b1000, 4'b0100, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b0101, 2'b01},
    '{4'd5,  1'b0, 2'b00, 1'b0, 1'b1, 4'b1100, 4'b1000, 1'b0, 1'b0, 1'b0, 4'b1111, 4'b1010, 2'b01},
    '{4'd6,  1'b0, 2'b11, 1'b1, 1'b1, 4'b1100, 4'b1100, 1'b1, 1'b0, 1'b1, 4'b1100, 4'b1100, 2'b10},
    '{4'd6,  1'b0, 2'b01, 1'b1, 1'b0, 4'b1100, 4'b0100, 1'b0, 1'b1, 1'b1, 4'b1100, 4'b0100, 2'b10},
    '{4'd7,  1'b1, 2'b01, 1'b1, 1'b0, 4'b0011, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0011, 4'b0001, 2'b01},
    '{4'd7,  1'b1, 2'b01, 1'b1, 1'b0, 4'b1011, 4'b0110, 1'b0, 1'b0, 1'b0, 4'b1011, 4'b0111, 2'b01},
    '{4'd8,  1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0000, 2'b11},
    '{4'd8,  1'b0, 2'b00, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000, 2'b11},
    '{4'd9,  1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000, 2'b10},
    '{4'd10, 1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000, 2'b01}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       virt_i = 1'b0;
  logic [1:0] priv_i = 2'b00;
  logic       hcfg_fiom_i = 1'b0;
  logic       mcfg_fiom_i = 1'b0;
  logic [3:0] pred_i = 4'b0000;
  logic [3:0] succ_i = 4'b0000;
  logic       amo_aq_i = 1'b0;
  logic       amo_rl_i = 1'b0;
  logic       amo_io_i = 1'b0;
  logic [3:0] pred_o;
  logic [3:0] succ_o;
  logic [1:0] amo_dom_o;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fence_widen u_dut (
    .virt_i      (virt_i),
    .priv_i      (priv_i),
    .hcfg_fiom_i (hcfg_fiom_i),
    .mcfg_fiom_i (mcfg_fiom_i),
    .pred_i      (pred_i),
    .succ_i      (succ_i),
    .amo_aq_i    (amo_aq_i),
    .amo_rl_i    (amo_rl_i),
    .amo_io_i    (amo_io_i),
    .pred_o      (pred_o),
    .succ_o      (succ_o),
    .amo_dom_o   (amo_dom_o)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pred,succ,dom} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    virt_i      = v.virt;
    priv_i      = v.priv;
    hcfg_fiom_i = v.hcfg;
    mcfg_fiom_i = v.mcfg;
    pred_i      = v.pred;
    succ_i      = v.succ;
    amo_aq_i    = v.aq;
    amo_rl_i    = v.rl;
    amo_io_i    = v.io;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state: all-zero inputs give empty sets and memory domain (R10)
    repeat (3) @(negedge clk);
    check("R10 reset", {pred_o, succ_o, amo_dom_o}, {4'b0000, 4'b0000, 2'b01});
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {pred_o, succ_o, amo_dom_o},
            {VECS[i].e_pred, VECS[i].e_succ, VECS[i].e_dom});
    end

    // R6: machine level with both bits set, every set combination passes through
    for (int s = 0; s < 256; s++) begin
      vec_t v;
      v = '0;
      v.priv = 2'b11;
      v.hcfg = 1'b1;
      v.mcfg = 1'b1;
      v.pred = s[7:4];
      v.succ = s[3:0];
      apply(v);
      check("R6 sweep", {pred_o, succ_o, amo_dom_o}, {s[7:4], s[3:0], 2'b01});
    end

    // R7: active widening keeps every input bit and the device bits
    for (int s = 0; s < 256; s++) begin
      vec_t v;
      v = '0;
      v.virt = 1'b1;
      v.priv = 2'b00;
      v.hcfg = 1'b1;
      v.pred = s[7:4];
      v.succ = s[3:0];
      apply(v);
      check("R7 keep", {pred_o & s[7:4], succ_o & s[3:0], pred_o[3:2], succ_o[3:2]},
            {s[7:4], s[3:0], s[7:6], s[3:2]});
    end

    // R9: unordered I/O atomic stays I/O only under every activation
    for (int m = 0; m < 2; m++) begin
      vec_t v;
      v = '0;
      v.priv = 2'b01;
      v.virt = 1'(m);
      v.hcfg = 1'b1;
      v.mcfg = 1'b1;
      v.io   = 1'b1;
      apply(v);
      check("R9 corner", {4'b0000, 4'b0000, amo_dom_o}, {4'b0000, 4'b0000, 2'b10});
    end

    // R10: memory atomic with aq and rl under active widening
    begin
      vec_t v;
      v = '0;
      v.priv = 2'b00;
      v.mcfg = 1'b1;
      v.aq   = 1'b1;
      v.rl   = 1'b1;
      apply(v);
      check("R10 corner", {4'b0000, 4'b0000, amo_dom_o}, {4'b0000, 4'b0000, 2'b01});
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule